// File: doc/BRIEF.md
# Queue-Occupancy Fetch-Gating Controller

This block decides, cycle by cycle, whether a packet-processing micro-engine fetches and executes instructions or sits in a power-saving gated state. It tracks how many packets wait in the engine's input queue by following push and pop strobes from the queue. Whenever that count changes, it compares the new count with a programmed threshold. The threshold is the occupancy at which the engine must run flat out to keep its worst-case throughput.

When a computation-reuse cache lets the engine skip work, the engine gains slack and the queue stays short. The controller turns that slack into idle cycles. It gates fetch while the queue holds fewer packets than the threshold. It releases the gate as soon as the count reaches the threshold, so that no packet is dropped. A global enable input forces normal fetch. A free-running counter totals the gated cycles, which is used for energy accounting.

Top module: `fetch_gate_ctrl`

## Requirements
- R1: After reset, occupancy_o is 0, gated_o is 0, fetch_en_o is 1 and gated_cycles_o is 0.
- R2: occupancy_o rises by one on a cycle with push_i alone and falls by one on a cycle with pop_i alone. It holds when both strobes are high or both are low.
- R3: occupancy_o saturates: a lone push at QUEUE_DEPTH and a lone pop at 0 leave it unchanged, and such a cycle does not count as a length change.
- R4: The gate decision is re-evaluated only on a clock edge where occupancy_o actually changes. A threshold change, an idle cycle or a simultaneous push and pop leaves gated_o as it was.
- R5: On a length change with enable_i high, gated_o becomes 1 if the new occupancy is strictly below threshold_i and 0 otherwise. It takes effect in the same edge as the occupancy update.
- R6: On the edge where the occupancy rises to threshold_i, gated_o falls to 0, and fetch_en_o is 1 from that edge on.
- R7: Only two levels exist. fetch_en_o is always the inverse of gated_o.
- R8: enable_i low forces gated_o to 0 at the next edge. After enable_i returns high, gated_o stays 0 until the next length change.
- R9: gated_cycles_o is a 32-bit count that rises by one after every cycle in which gated_o was 1 and holds otherwise. It wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global gating permission; low forces normal fetch |
| push_i | input | 1 | A packet entered the input queue this cycle |
| pop_i | input | 1 | A packet left the input queue this cycle |
| threshold_i | input | $clog2(QUEUE_DEPTH+1) | Worst-case-throughput occupancy threshold |
| occupancy_o | output | $clog2(QUEUE_DEPTH+1) | Tracked queue occupancy |
| gated_o | output | 1 | Engine is in the gated power-saving state |
| fetch_en_o | output | 1 | Engine may fetch and execute instructions |
| gated_cycles_o | output | 32 | Number of cycles spent gated |

## Verification
The hardest situation to reach is a stale decision. That is a gate state that no longer matches the current comparison, because the threshold moved, enable_i toggled, or the strobes cancelled while the length stayed fixed. The stimulus reaches it on purpose. It gates at a low count, then lowers the threshold below the occupancy and idles. It drops and restores enable_i with no queue traffic. It drives push and pop together, and it issues pushes into a full queue and pops from an empty one. Each such cycle is followed by checks that the gate and the cycle count kept their earlier course.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  typedef enum logic {
    FETCH_RUN   = 1'b0,
    FETCH_GATED = 1'b1
  } fetch_mode_e;
endpackage

// File: rtl/fgc_occ_counter.sv
module fgc_occ_counter #(
  parameter int QUEUE_DEPTH = 16,
  parameter int OCC_W       = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [OCC_W-1:0] occ_o,
  output logic [OCC_W-1:0] occ_next_o,
  output logic             changed_o
);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(QUEUE_DEPTH);

  logic [OCC_W-1:0] occ_q;
  logic             inc, dec;

  // saturating at both ends; a blocked step is no length change
  assign inc = push_i & ~pop_i & (occ_q != FULL);
  assign dec = pop_i & ~push_i & (occ_q != '0);

  always_comb begin
    occ_next_o = occ_q;
    if (inc)      occ_next_o = occ_q + OCC_W'(1);
    else if (dec) occ_next_o = occ_q - OCC_W'(1);
  end

  assign changed_o = inc | dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_next_o;
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/fgc_gate_fsm.sv
module fgc_gate_fsm
  import fgc_pkg::*;
#(
  parameter int OCC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             changed_i,
  input  logic [OCC_W-1:0] occ_next_i,
  input  logic [OCC_W-1:0] threshold_i,
  output logic             gated_o,
  output logic             fetch_en_o
);
  fetch_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!enable_i)
      mode_d = FETCH_RUN;
    else if (changed_i)
      mode_d = (occ_next_i < threshold_i) ? FETCH_GATED : FETCH_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= FETCH_RUN;
    else         mode_q <= mode_d;
  end

  assign gated_o    = (mode_q == FETCH_GATED);
  assign fetch_en_o = (mode_q == FETCH_RUN);
endmodule

// File: rtl/fgc_cycle_counter.sv
module fgc_cycle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/fetch_gate_ctrl.sv
module fetch_gate_ctrl #(
  parameter int QUEUE_DEPTH = 16,
  parameter int CNT_W       = 32,
  localparam int OCC_W      = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [OCC_W-1:0] threshold_i,
  output logic [OCC_W-1:0] occupancy_o,
  output logic             gated_o,
  output logic             fetch_en_o,
  output logic [CNT_W-1:0] gated_cycles_o
);
  logic [OCC_W-1:0] occ_next;
  logic             len_changed;

  fgc_occ_counter #(.QUEUE_DEPTH(QUEUE_DEPTH), .OCC_W(OCC_W)) u_occ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .occ_o      (occupancy_o),
    .occ_next_o (occ_next),
    .changed_o  (len_changed)
  );

  fgc_gate_fsm #(.OCC_W(OCC_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .changed_i   (len_changed),
    .occ_next_i  (occ_next),
    .threshold_i (threshold_i),
    .gated_o     (gated_o),
    .fetch_en_o  (fetch_en_o)
  );

  fgc_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (gated_o),
    .count_o (gated_cycles_o)
  );
endmodule

// File: rtl/fetch_gate_ctrl_chk.sv
module fetch_gate_ctrl_chk #(
  parameter int QUEUE_DEPTH = 16,
  parameter int CNT_W       = 32,
  parameter int OCC_W       = $clog2(QUEUE_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             push_i,
  input logic             pop_i,
  input logic [OCC_W-1:0] threshold_i,
  input logic [OCC_W-1:0] occupancy_o,
  input logic             gated_o,
  input logic             fetch_en_o,
  input logic [CNT_W-1:0] gated_cycles_o
);
  logic step_up, step_dn;
  assign step_up = push_i & ~pop_i & (occupancy_o < OCC_W'(QUEUE_DEPTH));
  assign step_dn = pop_i & ~push_i & (occupancy_o != '0);

  assert_occ_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occupancy_o <= OCC_W'(QUEUE_DEPTH));

  assert_occ_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_up |=> occupancy_o == $past(occupancy_o) + OCC_W'(1));

  assert_occ_dn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_dn |=> occupancy_o == $past(occupancy_o) - OCC_W'(1));

  assert_occ_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i == pop_i) |=> $stable(occupancy_o));

  assert_no_reeval_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !step_up && !step_dn) |=> $stable(gated_o));

  assert_decide_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && (step_up || step_dn)) |=> gated_o == (occupancy_o < $past(threshold_i)));

  assert_two_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o != gated_o);

  assert_force_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !gated_o);

  assert_cnt_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated_o |=> gated_cycles_o == $past(gated_cycles_o) + CNT_W'(1));

  assert_cnt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gated_o |=> $stable(gated_cycles_o));
endmodule

bind fetch_gate_ctrl fetch_gate_ctrl_chk #(
  .QUEUE_DEPTH(QUEUE_DEPTH), .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .push_i         (push_i),
  .pop_i          (pop_i),
  .threshold_i    (threshold_i),
  .occupancy_o    (occupancy_o),
  .gated_o        (gated_o),
  .fetch_en_o     (fetch_en_o),
  .gated_cycles_o (gated_cycles_o)
);

// File: tb/tb_fetch_gate_ctrl.sv
`timescale 1ns/1ps
module tb_fetch_gate_ctrl;
  localparam int DEPTH = 16;
  localparam int OW    = $clog2(DEPTH + 1);

  typedef struct {
    logic [OW-1:0] occ;
    logic          gated;
    logic [31:0]   cnt;
    string         tag;
  } exp_t;

  logic          clk = 0, rst_n = 0;
  logic          en = 0, push = 0, pop = 0;
  logic [OW-1:0] thr = '0;
  logic [OW-1:0] occ;
  logic          gated, fetch_en;
  logic [31:0]   gcnt;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t sb[$];

  logic [OW-1:0] m_occ = '0;
  logic          m_gated = 0;
  logic [31:0]   m_cnt = '0;

  always #2 clk = ~clk;

  fetch_gate_ctrl #(.QUEUE_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .push_i(push), .pop_i(pop),
    .threshold_i(thr), .occupancy_o(occ), .gated_o(gated),
    .fetch_en_o(fetch_en), .gated_cycles_o(gcnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outcome
  task automatic step(input logic p, input logic q, input logic e,
                      input logic [OW-1:0] t, input string tag);
    exp_t x;
    logic inc, dec;
    @(negedge clk);
    push = p; pop = q; en = e; thr = t;
    m_cnt = m_cnt + (m_gated ? 32'd1 : 32'd0);
    inc = p && !q && (m_occ != OW'(DEPTH));
    dec = q && !p && (m_occ != '0);
    if (inc) m_occ = m_occ + OW'(1);
    if (dec) m_occ = m_occ - OW'(1);
    if (!e) m_gated = 0;
    else if (inc || dec) m_gated = (m_occ < t);
    x.occ = m_occ; x.gated = m_gated; x.cnt = m_cnt; x.tag = tag;
    sb.push_back(x);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        chk({x.tag, " occ R2"}, 32'(occ), 32'(x.occ));
        chk({x.tag, " gate R5"}, 32'(gated), 32'(x.gated));
        chk({x.tag, " fetch R7"}, 32'(fetch_en), 32'(!x.gated));
        chk({x.tag, " cnt R9"}, gcnt, x.cnt);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #10;
    chk("R1 occ", 32'(occ), 0);
    chk("R1 gated", 32'(gated), 0);
    chk("R1 fetch_en", 32'(fetch_en), 1);
    chk("R1 cnt", gcnt, 0);
    @(negedge clk); rst_n = 1;
    step(0, 0, 1, OW'(4), "R1 idle stays run");
    step(1, 0, 1, OW'(4), "R5 push to 1 gates");
    step(1, 0, 1, OW'(4), "R5 push to 2");
    step(1, 0, 1, OW'(4), "R5 push to 3");
    step(1, 0, 1, OW'(4), "R6 reach threshold releases");
    step(0, 1, 1, OW'(4), "R5 pop to 3 regates");
    step(1, 1, 1, OW'(4), "R4 push and pop together");
    step(0, 0, 1, OW'(2), "R4 threshold drop no reeval");
    step(0, 0, 1, OW'(2), "R4 idle keeps stale gate");
    step(0, 1, 1, OW'(2), "R6 pop to 2 at threshold");
    step(0, 1, 1, OW'(2), "R5 pop to 1 gates");
    for (int i = 0; i < 5; i++) step(0, 0, 1, OW'(2), "R9 gated accumulate");
    step(0, 0, 0, OW'(2), "R8 enable low forces run");
    step(0, 0, 1, OW'(2), "R8 enable back stays run");
    step(0, 0, 1, OW'(2), "R8 still run");
    step(0, 1, 1, OW'(2), "R5 pop to 0 gates");
    step(0, 1, 1, OW'(2), "R3 pop at empty");
    step(0, 1, 1, OW'(0), "R3 pop at empty thr 0");
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 1, OW'(0), "R3 fill thr 0");
    step(1, 0, 1, OW'(DEPTH), "R3 push at full");
    step(1, 1, 1, OW'(DEPTH), "R4 both at full");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, 1, OW'(DEPTH), "R5 drain");
    step(1, 0, 0, OW'(DEPTH), "R8 push while disabled");
    step(0, 1, 1, OW'(DEPTH), "R5 pop after enable");
    for (int i = 0; i < 3; i++) step(0, 0, 1, OW'(DEPTH), "R9 final count");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule